// File: doc/BRIEF.md
# Ramp Histogram Static Linearity Analyzer

This block measures the static linearity of an N-bit converter from the codes it produces while its input is swept by a slow, linear ramp. During capture it counts, in one saturating counter per code, how many valid samples landed on each code. When capture is stopped, it walks the codes in order. From the running sums it forms each code-boundary position in sample units, and reports the following:

- offset, gain error, per-code DNL and per-code INL, as signed fixed-point values with 8 fractional bits;
- missing codes;
- whether the ramp was too fast to give a trustworthy result.

The unit of measure is one LSB. It is taken from the occupied inner codes, so the two end codes, which collect any over-range samples, do not distort the scale. The DNL and INL figures are referenced to the end points: they are read against the straight line through the first and the last inner boundary. A single divider is shared by all phases, and the walk retires one code per cycle.

Top module: `hist_ramp_analyzer`

Definitions used below:

- K = 2^CODE_W and M = K-2.
- h[c] is the stored count of code c.
- span = h[1]+...+h[K-2] and total = h[0]+...+h[K-1].
- C[j] = h[1]+...+h[j-1], which is the boundary position TP[j]-TP[1].
- S[j] = floor(C[j]·M·256/span).
- All fixed-point values are two's complement with 8 fractional bits (256 = 1.0).

## Requirements
- R1: A cycle with `start` high clears every count, result and flag, drops `done`, and begins capture. A sample presented in that same cycle is not counted.
- R2: While capturing, each cycle with `code_valid` high adds one to the count of `code`, including the cycle in which `stop` is accepted. Samples arriving before the first `start`, during the walk or after `done` leave every count unchanged.
- R3: A count never wraps. A sample that arrives for a code whose count already equals 2^CNT_W-1 is dropped, and `overflow` is set and stays set until the next `start`.
- R4: `done` rises exactly K+1 cycles after the cycle in which `stop` is accepted, and then stays high until `start`.
- R5: `offset_q8` = floor(h[0]·M·256/span) - 128, which is the first boundary minus half an LSB.
- R6: `gain_q8` = floor(span·25600/total) - floor(M·25600/K). This is the gain error in percent of full scale, taking total/K as the ideal LSB. It is 0 when total is 0.
- R7: For j in 1..K-1, `rd_inl_q8` at code j equals S[j] - 256·(j-1). At code 0 it reads 0.
- R8: For j in 1..K-2, `rd_dnl_q8` at code j equals S[j+1] - S[j] - 256. At codes 0 and K-1 it reads 0.
- R9: `rd_missing` is high exactly when the count of `rd_code` is zero. `any_missing` is high exactly when at least one code's count is zero.
- R10: After the walk, `low_hits` is high exactly when span < 16·M, meaning the ramp averaged fewer than 16 samples per inner code.
- R11: When span is 0, `span_zero` is high after the walk, and the offset, every DNL and INL value, and both maxima are 0.
- R12: `max_dnl_q8` and `max_inl_q8` hold the largest magnitude among the reported DNL and INL values. `max_dnl_code` and `max_inl_code` hold the lowest code that reaches that magnitude, and are 0 when every value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear and begin a capture |
| stop | input | 1 | End capture and launch the walk |
| code_valid | input | 1 | `code` carries a sample this cycle |
| code | input | CODE_W | Converter output code |
| rd_code | input | CODE_W | Code selected on the readout port |
| done | output | 1 | Results complete |
| offset_q8 | output | CNT_W+CODE_W+10 | Offset in LSB, signed Q8 |
| gain_q8 | output | 17 | Gain error in percent of full scale, signed Q8 |
| max_dnl_q8 | output | CODE_W+10 | Largest DNL magnitude, Q8 |
| max_dnl_code | output | CODE_W | Code of the largest DNL |
| max_inl_q8 | output | CODE_W+10 | Largest INL magnitude, Q8 |
| max_inl_code | output | CODE_W | Code of the largest INL |
| low_hits | output | 1 | Ramp too fast |
| overflow | output | 1 | A count saturated |
| span_zero | output | 1 | No inner-code samples |
| any_missing | output | 1 | Some code has zero count |
| rd_hits | output | CNT_W | Count of `rd_code` |
| rd_dnl_q8 | output | CODE_W+10 | DNL of `rd_code`, signed Q8 |
| rd_inl_q8 | output | CODE_W+10 | INL of `rd_code`, signed Q8 |
| rd_missing | output | 1 | `rd_code` has zero count |

## Verification
The bench builds the block with CODE_W = 3 and CNT_W = 6. That gives 8 codes and counters that saturate at 63, so a single ramp of a few hundred samples exercises every one of the following:

- every code on the readout port;
- saturation on one code;
- both sides of the 16-per-code threshold (exactly 96 versus 90 inner samples);
- missing end and inner codes;
- the span-zero and empty-capture cases.

The expected offset, gain, DNL, INL and maxima are recomputed in integer arithmetic from the hit patterns the bench drives. Stray samples are driven throughout the walk and after `done`, so that the freeze of the counts can be seen.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CAP  = 3'd1,
        ST_EVAL = 3'd2,
        ST_GAIN = 3'd3,
        ST_DONE = 3'd4
    } hist_state_e;

endpackage

// File: rtl/hist_bins.sv
module hist_bins #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [CODE_W-1:0] inc_code,
    input  logic [CODE_W-1:0] rd_a_code,
    input  logic [CODE_W-1:0] rd_b_code,
    output logic [CNT_W-1:0]  rd_a_data,
    output logic [CNT_W-1:0]  rd_b_data,
    output logic              bump,
    output logic [(1<<CODE_W)-1:0] zero_vec
);
    localparam int K = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] bins_q [K];
    logic [CNT_W-1:0] bins_d [K];

    // a sample is only stored when its counter has headroom
    assign bump      = inc && (bins_q[inc_code] != CNT_MAX);
    assign rd_a_data = bins_q[rd_a_code];
    assign rd_b_data = bins_q[rd_b_code];

    always_comb begin
        for (int i = 0; i < K; i++) begin
            bins_d[i] = clr ? '0 : bins_q[i];
        end
        if (!clr && bump) begin
            bins_d[inc_code] = bins_q[inc_code] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < K; i++) begin
            if (!rst_n) bins_q[i] <= '0;
            else        bins_q[i] <= bins_d[i];
        end
    end

    for (genvar g = 0; g < K; g++) begin : g_zero
        assign zero_vec[g] = (bins_q[g] == '0);
    end

endmodule

// File: rtl/hist_divq.sv
module hist_divq #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 22
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo
);
    // floor quotient, forced to zero for a zero divisor
    always_comb begin
        if (den == '0) quo = '0;
        else           quo = num / NUM_W'(den);
    end
endmodule

// File: rtl/hist_results.sv
module hist_results #(
    parameter int CODE_W = 6,
    parameter int RES_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     inl_we,
    input  logic [CODE_W-1:0]        inl_code,
    input  logic signed [RES_W-1:0]  inl_val,
    input  logic                     dnl_we,
    input  logic [CODE_W-1:0]        dnl_code,
    input  logic signed [RES_W-1:0]  dnl_val,
    input  logic [CODE_W-1:0]        rd_code,
    output logic signed [RES_W-1:0]  rd_inl,
    output logic signed [RES_W-1:0]  rd_dnl
);
    localparam int K = 1 << CODE_W;

    logic signed [RES_W-1:0] inl_q [K];
    logic signed [RES_W-1:0] inl_d [K];
    logic signed [RES_W-1:0] dnl_q [K];
    logic signed [RES_W-1:0] dnl_d [K];

    always_comb begin
        for (int i = 0; i < K; i++) begin
            inl_d[i] = clr ? '0 : inl_q[i];
            dnl_d[i] = clr ? '0 : dnl_q[i];
        end
        if (!clr && inl_we) inl_d[inl_code] = inl_val;
        if (!clr && dnl_we) dnl_d[dnl_code] = dnl_val;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < K; i++) begin
            if (!rst_n) begin
                inl_q[i] <= '0;
                dnl_q[i] <= '0;
            end else begin
                inl_q[i] <= inl_d[i];
                dnl_q[i] <= dnl_d[i];
            end
        end
    end

    assign rd_inl = inl_q[rd_code];
    assign rd_dnl = dnl_q[rd_code];

endmodule

// File: rtl/hist_ramp_analyzer.sv
module hist_ramp_analyzer #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          stop,
    input  logic                          code_valid,
    input  logic [CODE_W-1:0]             code,
    input  logic [CODE_W-1:0]             rd_code,
    output logic                          done,
    output logic signed [CNT_W+CODE_W+9:0] offset_q8,
    output logic signed [16:0]            gain_q8,
    output logic [CODE_W+9:0]             max_dnl_q8,
    output logic [CODE_W-1:0]             max_dnl_code,
    output logic [CODE_W+9:0]             max_inl_q8,
    output logic [CODE_W-1:0]             max_inl_code,
    output logic                          low_hits,
    output logic                          overflow,
    output logic                          span_zero,
    output logic                          any_missing,
    output logic [CNT_W-1:0]              rd_hits,
    output logic signed [CODE_W+9:0]      rd_dnl_q8,
    output logic signed [CODE_W+9:0]      rd_inl_q8,
    output logic                          rd_missing
);
    import hist_pkg::*;

    localparam int K       = 1 << CODE_W;
    localparam int M       = K - 2;
    localparam int CUM_W   = CNT_W + CODE_W;
    localparam int RES_W   = CODE_W + 10;
    localparam int OFF_W   = CNT_W + CODE_W + 10;
    localparam int GAIN_W  = 17;
    localparam int NUM_W   = CUM_W + CODE_W + 15;
    localparam int MIN_AVG = 16;
    localparam int ONE_Q8  = 256;
    localparam int PCT_Q8  = 100 * ONE_Q8;

    localparam logic [NUM_W-1:0]         M_SCALE    = NUM_W'(M * ONE_Q8);
    localparam logic [NUM_W-1:0]         PCT_SCALE  = NUM_W'(PCT_Q8);
    localparam logic signed [GAIN_W-1:0] GAIN_IDEAL = GAIN_W'((M * PCT_Q8) / K);
    localparam logic [CUM_W-1:0]         LOW_LIMIT  = CUM_W'(MIN_AVG * M);
    localparam logic [CODE_W-1:0]        LAST_CODE  = CODE_W'(K - 1);

    typedef struct packed {
        hist_state_e              st;
        logic [CODE_W-1:0]        idx;
        logic [CUM_W-1:0]         cum;
        logic [CUM_W-1:0]         span;
        logic [CUM_W-1:0]         total;
        logic signed [RES_W-1:0]  s_prev;
        logic signed [OFF_W-1:0]  offset;
        logic signed [GAIN_W-1:0] gain;
        logic                     low;
        logic                     szero;
        logic                     ovf;
        logic [RES_W-1:0]         max_dnl;
        logic [CODE_W-1:0]        max_dnl_c;
        logic [RES_W-1:0]         max_inl;
        logic [CODE_W-1:0]        max_inl_c;
    } ana_regs_t;

    ana_regs_t r_q, r_d;

    logic                    bins_clr, bins_inc, bins_bump;
    logic [CNT_W-1:0]        walk_hits;
    logic [K-1:0]            zero_vec;
    logic [NUM_W-1:0]        div_num, div_q;
    logic [CUM_W-1:0]        div_den;
    logic                    inl_we, dnl_we;
    logic [CODE_W-1:0]       dnl_code;
    logic signed [RES_W-1:0] inl_val, dnl_val;
    logic signed [RES_W-1:0] s_now;
    logic [RES_W-1:0]        line_u;
    logic                    in_capture, in_gain;

    function automatic logic [RES_W-1:0] mag(input logic signed [RES_W-1:0] v);
        return (v < 0) ? RES_W'(-v) : RES_W'(v);
    endfunction

    hist_bins #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bins_clr),
        .inc       (bins_inc),
        .inc_code  (code),
        .rd_a_code (r_q.idx),
        .rd_b_code (rd_code),
        .rd_a_data (walk_hits),
        .rd_b_data (rd_hits),
        .bump      (bins_bump),
        .zero_vec  (zero_vec)
    );

    hist_divq #(.NUM_W(NUM_W), .DEN_W(CUM_W)) u_div (
        .num (div_num),
        .den (div_den),
        .quo (div_q)
    );

    hist_results #(.CODE_W(CODE_W), .RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bins_clr),
        .inl_we   (inl_we),
        .inl_code (r_q.idx),
        .inl_val  (inl_val),
        .dnl_we   (dnl_we),
        .dnl_code (dnl_code),
        .dnl_val  (dnl_val),
        .rd_code  (rd_code),
        .rd_inl   (rd_inl_q8),
        .rd_dnl   (rd_dnl_q8)
    );

    always_comb begin
        r_d      = r_q;
        bins_clr = 1'b0;
        bins_inc = 1'b0;
        div_num  = '0;
        div_den  = r_q.span;
        inl_we   = 1'b0;
        dnl_we   = 1'b0;
        dnl_code = r_q.idx - CODE_W'(1);
        s_now    = signed'(RES_W'(div_q));
        line_u   = RES_W'(r_q.idx - CODE_W'(1)) << 8;
        inl_val  = (r_q.span == '0) ? '0 : (s_now - signed'(line_u));
        dnl_val  = (r_q.span == '0) ? '0 : (s_now - r_q.s_prev - RES_W'(ONE_Q8));

        if (start) begin
            r_d      = '0;
            r_d.st   = ST_CAP;
            bins_clr = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_CAP: begin
                    bins_inc = code_valid;
                    if (bins_bump) begin
                        r_d.total = r_q.total + CUM_W'(1);
                        if (code != '0 && code != LAST_CODE) begin
                            r_d.span = r_q.span + CUM_W'(1);
                        end
                    end
                    if (code_valid && !bins_bump) r_d.ovf = 1'b1;
                    if (stop) begin
                        r_d.st  = ST_EVAL;
                        r_d.idx = '0;
                    end
                end
                ST_EVAL: begin
                    r_d.idx = r_q.idx + CODE_W'(1);
                    if (r_q.idx == '0) begin
                        // first boundary against the measured LSB
                        div_num = NUM_W'(walk_hits) * M_SCALE;
                        r_d.offset = (r_q.span == '0) ? '0
                                   : (signed'(OFF_W'(div_q)) - OFF_W'(ONE_Q8 / 2));
                        r_d.szero  = (r_q.span == '0);
                        r_d.low    = (r_q.span < LOW_LIMIT);
                        r_d.cum    = '0;
                        r_d.s_prev = '0;
                    end else begin
                        div_num  = NUM_W'(r_q.cum) * M_SCALE;
                        inl_we   = 1'b1;
                        dnl_we   = (r_q.idx != CODE_W'(1));
                        r_d.cum    = r_q.cum + CUM_W'(walk_hits);
                        r_d.s_prev = s_now;
                        if (mag(inl_val) > r_q.max_inl) begin
                            r_d.max_inl   = mag(inl_val);
                            r_d.max_inl_c = r_q.idx;
                        end
                        if (dnl_we && mag(dnl_val) > r_q.max_dnl) begin
                            r_d.max_dnl   = mag(dnl_val);
                            r_d.max_dnl_c = dnl_code;
                        end
                        if (r_q.idx == LAST_CODE) r_d.st = ST_GAIN;
                    end
                end
                ST_GAIN: begin
                    div_num  = NUM_W'(r_q.span) * PCT_SCALE;
                    div_den  = r_q.total;
                    r_d.gain = (r_q.total == '0) ? '0
                             : (signed'(GAIN_W'(div_q)) - GAIN_IDEAL);
                    r_d.st   = ST_DONE;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_capture   = (r_q.st == ST_CAP);
    assign in_gain      = (r_q.st == ST_GAIN);
    assign done         = (r_q.st == ST_DONE);
    assign offset_q8    = r_q.offset;
    assign gain_q8      = r_q.gain;
    assign max_dnl_q8   = r_q.max_dnl;
    assign max_dnl_code = r_q.max_dnl_c;
    assign max_inl_q8   = r_q.max_inl;
    assign max_inl_code = r_q.max_inl_c;
    assign low_hits     = r_q.low;
    assign overflow     = r_q.ovf;
    assign span_zero    = r_q.szero;
    assign any_missing  = |zero_vec;
    assign rd_missing   = (rd_hits == '0);

endmodule

// File: rtl/hist_ramp_analyzer_chk.sv
module hist_ramp_analyzer_chk #(
    parameter int CUM_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             overflow,
    input logic             in_capture,
    input logic             in_gain,
    input logic [CUM_W-1:0] span,
    input logic [CUM_W-1:0] total
);
    // R1: a start cycle leaves counts, done and overflow cleared
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (total == '0 && !done && !overflow));

    // R2: the sample tally only moves while capturing
    a_r2_frozen_outside_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_capture && !start) |=> $stable(total));

    // R3: saturation flag is sticky until the next start
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    // R4: done holds until start
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R4: done only follows the gain step
    a_r4_done_after_gain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_gain));

    // R11: inner samples never exceed all samples
    a_r11_span_le_total: assert property (@(posedge clk) disable iff (!rst_n)
        span <= total);
endmodule

bind hist_ramp_analyzer hist_ramp_analyzer_chk #(.CUM_W(CNT_W + CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .overflow   (overflow),
    .in_capture (in_capture),
    .in_gain    (in_gain),
    .span       (r_q.span),
    .total      (r_q.total)
);

// File: tb/hist_ramp_analyzer_tb.sv
module hist_ramp_analyzer_tb;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 6;
    localparam int K      = 1 << CODE_W;
    localparam int M      = K - 2;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, code_valid = 1'b0;
    logic [CODE_W-1:0] code = '0, rd_code = '0;
    logic done, low_hits, overflow, span_zero, any_missing, rd_missing;
    logic signed [CNT_W+CODE_W+9:0] offset_q8;
    logic signed [16:0] gain_q8;
    logic [CODE_W+9:0] max_dnl_q8, max_inl_q8;
    logic [CODE_W-1:0] max_dnl_code, max_inl_code;
    logic [CNT_W-1:0] rd_hits;
    logic signed [CODE_W+9:0] rd_dnl_q8, rd_inl_q8;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hist_ramp_analyzer #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .code_valid(code_valid), .code(code), .rd_code(rd_code),
        .done(done), .offset_q8(offset_q8), .gain_q8(gain_q8),
        .max_dnl_q8(max_dnl_q8), .max_dnl_code(max_dnl_code),
        .max_inl_q8(max_inl_q8), .max_inl_code(max_inl_code),
        .low_hits(low_hits), .overflow(overflow), .span_zero(span_zero),
        .any_missing(any_missing), .rd_hits(rd_hits), .rd_dnl_q8(rd_dnl_q8),
        .rd_inl_q8(rd_inl_q8), .rd_missing(rd_missing)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int c, input bit st, input bit sp);
        code_valid = v;
        code       = CODE_W'(c);
        start      = st;
        stop       = sp;
        @(negedge clk);
    endtask

    // drives one ramp of hit counts h and checks every result
    task automatic run(input int h[K], input bit ovf_exp);
        int hs[K];
        longint span, total, s[K], inl[K], dnl[K], off, gain, mx_d, mx_i;
        int c_d, c_i, last;
        bit anym;
        drive(1, 0, 1, 0);                       // R1: sample with start dropped
        last = -1;
        for (int c = 0; c < K; c++) if (h[c] > 0) last = c;
        for (int c = 0; c < K; c++) begin
            for (int n = 0; n < h[c]; n++) begin
                drive(1, c, 0, (c == last && n == h[c] - 1));
            end
        end
        if (last < 0) drive(0, 0, 0, 1);
        // R2: samples during the walk are ignored; R4: done latency
        for (int n = 0; n < K; n++) drive(1, 3, 0, 0);
        chk("R4", "done before K+1", longint'(done), 0);
        drive(1, 5, 0, 0);
        chk("R4", "done at K+1", longint'(done), 1);
        drive(1, 5, 0, 0);
        drive(0, 0, 0, 0);
        chk("R4", "done held", longint'(done), 1);

        span = 0; total = 0; anym = 0;
        for (int c = 0; c < K; c++) begin
            hs[c] = (h[c] > CMAX) ? CMAX : h[c];
            total += hs[c];
            if (c != 0 && c != K - 1) span += hs[c];
            if (hs[c] == 0) anym = 1;
        end
        for (int c = 0; c < K; c++) begin inl[c] = 0; dnl[c] = 0; s[c] = 0; end
        off = 0;
        if (span != 0) begin
            longint cum;
            off = (longint'(hs[0]) * M * 256) / span - 128;
            cum = 0;
            for (int j = 1; j < K; j++) begin
                s[j] = (cum * M * 256) / span;
                inl[j] = s[j] - 256 * (j - 1);
                cum += hs[j];
            end
            for (int j = 1; j < K - 1; j++) dnl[j] = s[j + 1] - s[j] - 256;
        end
        gain = (total == 0) ? 0 : (span * 25600) / total - (longint'(M) * 25600) / K;
        mx_d = 0; mx_i = 0; c_d = 0; c_i = 0;
        for (int j = 1; j < K; j++) begin
            longint a;
            a = (inl[j] < 0) ? -inl[j] : inl[j];
            if (a > mx_i) begin mx_i = a; c_i = j; end
            a = (dnl[j] < 0) ? -dnl[j] : dnl[j];
            if (a > mx_d) begin mx_d = a; c_d = j; end
        end

        chk("R5", "offset", longint'(offset_q8), off);
        chk("R6", "gain", longint'(gain_q8), gain);
        chk("R3", "overflow", longint'(overflow), longint'(ovf_exp));
        chk("R10", "low_hits", longint'(low_hits), longint'(span < 16 * M));
        chk("R11", "span_zero", longint'(span_zero), longint'(span == 0));
        chk("R9", "any_missing", longint'(any_missing), longint'(anym));
        chk("R12", "max dnl", longint'(max_dnl_q8), mx_d);
        chk("R12", "max dnl code", longint'(max_dnl_code), c_d);
        chk("R12", "max inl", longint'(max_inl_q8), mx_i);
        chk("R12", "max inl code", longint'(max_inl_code), c_i);
        for (int c = 0; c < K; c++) begin
            rd_code = CODE_W'(c);
            #1;
            chk("R2", $sformatf("hits[%0d]", c), longint'(rd_hits), hs[c]);
            chk("R9", $sformatf("missing[%0d]", c), longint'(rd_missing), longint'(hs[c] == 0));
            chk("R7", $sformatf("inl[%0d]", c), longint'(rd_inl_q8), inl[c]);
            chk("R8", $sformatf("dnl[%0d]", c), longint'(rd_dnl_q8), dnl[c]);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int hA[K], hB[K], hC[K], hD[K], hE[K], hF[K];
        hA = '{16, 16, 16, 16, 16, 16, 16, 16};
        hB = '{5, 20, 0, 30, 10, 20, 16, 3};
        hC = '{15, 15, 15, 15, 15, 15, 15, 15};
        hD = '{0, 10, 12, 70, 8, 9, 11, 0};
        hE = '{4, 0, 0, 0, 0, 0, 0, 9};
        hF = '{0, 0, 0, 0, 0, 0, 0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: samples before any start are ignored
        drive(1, 2, 0, 0);
        drive(1, 2, 0, 1);
        drive(0, 0, 0, 0);
        chk("R4", "reset done", longint'(done), 0);
        chk("R3", "reset overflow", longint'(overflow), 0);
        chk("R2", "reset hits", longint'(rd_hits), 0);
        chk("R9", "reset any_missing", longint'(any_missing), 1);
        run(hA, 0);   // exact 16 per code: low_hits boundary, all zero errors
        run(hB, 0);   // uneven widths with an inner missing code
        run(hC, 0);   // 15 per code: low_hits
        run(hD, 1);   // saturating code, missing end codes
        run(hE, 0);   // R11: only end codes hit
        run(hF, 0);   // empty capture clears prior state (R1)
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule